// File: doc/BRIEF.md
# Paged open-drain I/O port controller

The block gives a host byte-wide access to 48 open-drain digital lines. The lines are grouped into six 8-line ports inside a 16-byte register window. The interface is a simple synchronous bus with an address, write data, read data and separate read and write strobes. There is no direction register. Setting a port bit to 1 turns on the pad's pull-down, so the line goes low. Clearing the bit releases the line, which then floats high and can be used as an input. A port read returns the inverse of the synchronized pin level, so a 1 means the line is low.

A write-only control register at offset 0x7 holds two fields:
- a 2-bit page selector in bits 7:6;
- six per-port write-lock bits in bits 5:0, where bit n locks port n.

The page selector decides what appears at the three shared offsets 0x8, 0x9 and 0xA:
- page 0: nothing;
- page 1: the polarity registers of an attached interrupt unit;
- page 2: the enable registers of that unit;
- page 3: its interrupt-ID registers.

The controller does not hold any of those registers. It forwards the paged accesses to the interrupt unit with the page and a register index. It returns the unit's pending summary at offset 0x6 on every page. It also hands the synchronized pin levels to the unit for edge detection.

Top module: `paged_od_ioport`

## Requirements
- R1: After reset all port registers are zero, so no pull-down is on and every line is released high. The page field and all lock bits are zero, and the read data output is zero.
- R2: A write to offset n (0x0 to 0x5) of an unlocked port loads the write data into port n. From the next cycle, line 8n+k has its pull-down on exactly when bit k of the data is 1 (pad_drive_low high).
- R3: Each pin input passes through two flops before it is used. line_sync equals pad_in from two clock edges earlier. A read of port offset n returns bit k = 1 when synchronized line 8n+k is low and 0 when it is high.
- R4: A write to offset 0x7 sets the page from bits 7:6 and the lock bits from bits 5:0. A write to a port whose lock bit is 1 leaves that port register and its drive outputs unchanged. Reads of a locked port still return the inverted pin state. Offset 0x7 reads as zero.
- R5: On page 0, reads of offsets 0x8 to 0xA return zero. Writes to them do not assert iu_wr, and reads do not assert iu_rd.
- R6: On pages 1 and 2, a write to offset 0x8, 0x9 or 0xA asserts iu_wr in the same cycle, with iu_page equal to the page, iu_idx equal to 0, 1 or 2 (the offset minus 8) and iu_wdata equal to the write data. Reads of those offsets on these pages return zero and do not assert iu_rd.
- R7: On page 3, a read of offset 0x8 to 0xA asserts iu_rd in the same cycle and returns the iu_rdata value present in that cycle. A write there is forwarded as in R6, with iu_page equal to 3.
- R8: A read of offset 0x6 returns iu_pend in bits 2:0 and zero in bits 7:3, on every page.
- R9: Offsets 0xB to 0xF read as zero. Writes to them change no port register and do not assert iu_wr.
- R10: Read data is registered. bus_rdata shows the value of a read in the cycle after bus_rd is high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pin levels sampled from the pads |
| pad_drive_low | output | 48 | Pull-down enable for each line (1 = drive low) |
| line_sync | output | 48 | Synchronized pin levels for the interrupt unit |
| iu_wr | output | 1 | Write strobe for a paged register of the interrupt unit |
| iu_rd | output | 1 | Read strobe for an interrupt-ID register |
| iu_page | output | 2 | Currently selected page |
| iu_idx | output | 2 | Paged register index, 0 to 2 |
| iu_wdata | output | 8 | Write data forwarded to the interrupt unit |
| iu_rdata | input | 8 | Interrupt-ID read data from the interrupt unit |
| iu_pend | input | 3 | Pending summary from the interrupt unit |

## Verification
The bench builds the block with its default of six ports. That reaches every port offset, all six lock bits and the pending register that sits just above the last port. The pads are modelled as open-drain lines with an external pull-down. Reads therefore show both the block's own drive and outside pulls after the two-flop delay. The bench steps through all four pages, so each paged offset is seen as inert, write-only forwarded and readable.

// File: rtl/paged_od_ioport.sv
module paged_od_ioport #(
  parameter int NPORTS = 6,
  localparam int NLINES = NPORTS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_drive_low,
  output logic [NLINES-1:0] line_sync,
  output logic              iu_wr,
  output logic              iu_rd,
  output logic [1:0]        iu_page,
  output logic [1:0]        iu_idx,
  output logic [7:0]        iu_wdata,
  input  logic [7:0]        iu_rdata,
  input  logic [2:0]        iu_pend
);

  localparam logic [3:0] ADDR_PEND = 4'h6;
  localparam logic [3:0] ADDR_CTRL = 4'h7;

  logic [7:0]        port_q [NPORTS];
  logic [1:0]        page_q;
  logic [5:0]        lock_q;
  logic [NLINES-1:0] meta_q, sync_q;
  logic [7:0]        rd_val;
  logic              paged;
  logic [1:0]        age;

  assign paged    = (bus_addr >= 4'h8) && (bus_addr <= 4'hA);
  assign iu_page  = page_q;
  assign iu_idx   = bus_addr[1:0];
  assign iu_wdata = bus_wdata;
  assign iu_wr    = bus_wr && paged && (page_q != 2'd0);
  assign iu_rd    = bus_rd && paged && (page_q == 2'd3);
  assign line_sync = sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      lock_q <= '0;
    end else if (bus_wr && bus_addr == ADDR_CTRL) begin
      page_q <= bus_wdata[7:6];
      lock_q <= bus_wdata[5:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      age    <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) port_q[g] <= '0;
      else if (bus_wr && bus_addr == 4'(g) && !lock_q[g]) port_q[g] <= bus_wdata;
    end
    assign pad_drive_low[g*8 +: 8] = port_q[g];

    assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'(g) && lock_q[g]) |=> $stable(pad_drive_low[g*8 +: 8]));

    assert_port_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'(g) && !lock_q[g]) |=> pad_drive_low[g*8 +: 8] == $past(bus_wdata));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NPORTS; i++)
      if (bus_addr == 4'(i)) rd_val = ~sync_q[i*8 +: 8];
    if (bus_addr == ADDR_PEND) rd_val = {5'b0, iu_pend};
    else if (paged && page_q == 2'd3) rd_val = iu_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    age[1] |-> line_sync == $past(pad_in, 2));

  assert_page0_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && paged && page_q == 2'd0) |=> bus_rdata == 8'h00);

  assert_wo_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && paged && (page_q == 2'd1 || page_q == 2'd2)) |=> bus_rdata == 8'h00);

  assert_id_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && paged && page_q == 2'd3) |=> bus_rdata == $past(iu_rdata));

  assert_pend_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_PEND) |=> bus_rdata == {5'b0, $past(iu_pend)});

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr >= 4'hB || bus_addr == ADDR_CTRL)) |=> bus_rdata == 8'h00);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_paged_od_ioport.sv
`timescale 1ns/1ps
module tb_paged_od_ioport;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_rdata;
  logic [47:0] pad_in, pad_drive_low, line_sync, ext_low = 0;
  logic        iu_wr, iu_rd;
  logic [1:0]  iu_page, iu_idx;
  logic [7:0]  iu_wdata, iu_rdata;
  logic [2:0]  iu_pend = 0;
  int total = 0, bad = 0;
  logic       c_wr, c_rd;
  logic [1:0] c_page, c_idx;
  logic [7:0] c_wdata, rv;

  always #2.5 clk = ~clk;
  assign pad_in   = ~(pad_drive_low | ext_low);
  assign iu_rdata = 8'h90 + {6'b0, iu_idx};

  paged_od_ioport dut (.*);

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    #1 c_wr = iu_wr; c_page = iu_page; c_idx = iu_idx; c_wdata = iu_wdata;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 c_rd = iu_rd;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 drive", pad_drive_low, 48'h0);
    check("R1 rdata", {40'h0, bus_rdata}, 48'h0);
    rd(4'h8, rv); check("R1 page0 at reset", {40'h0, rv}, 48'h0);
    check("R1 no iu_rd", {47'h0, c_rd}, 48'h0);
  endtask

  task automatic t_drive();
    wr(4'h0, 8'h0F); check("R2 port0", pad_drive_low, 48'h0000_0000_000F);
    wr(4'h5, 8'hA5); check("R2 port5", pad_drive_low, 48'hA500_0000_000F);
    wr(4'h0, 8'h00); wr(4'h5, 8'h00);
    check("R2 cleared", pad_drive_low, 48'h0);
  endtask

  task automatic t_input();
    ext_low = 48'h0000_0000_3C00;
    wr(4'h0, 8'h81);
    settle();
    check("R3 line_sync", line_sync, ~(48'h0000_0000_3C81));
    rd(4'h1, rv); check("R3 ext pull port1", {40'h0, rv}, 48'h3C);
    rd(4'h0, rv); check("R3 own drive port0", {40'h0, rv}, 48'h81);
    rd(4'h2, rv); check("R3 released port2", {40'h0, rv}, 48'h00);
    ext_low = 0; wr(4'h0, 8'h00); settle();
    rd(4'h1, rv); check("R3 released port1", {40'h0, rv}, 48'h00);
  endtask

  task automatic t_lock();
    wr(4'h2, 8'h5A);
    wr(4'h7, 8'h04);
    wr(4'h2, 8'hFF); check("R4 locked write ignored", pad_drive_low[23:16], 48'h5A);
    wr(4'h3, 8'h11); check("R4 other port writable", pad_drive_low[31:24], 48'h11);
    settle();
    rd(4'h2, rv); check("R4 locked read", {40'h0, rv}, 48'h5A);
    rd(4'h7, rv); check("R4 ctrl reads zero", {40'h0, rv}, 48'h0);
    wr(4'h7, 8'h00);
    wr(4'h2, 8'h00); wr(4'h3, 8'h00);
    check("R4 unlocked", pad_drive_low, 48'h0);
  endtask

  task automatic t_page0();
    wr(4'h8, 8'hEE); check("R5 no iu_wr page0", {47'h0, c_wr}, 48'h0);
    rd(4'h9, rv); check("R5 read page0", {40'h0, rv}, 48'h0);
    check("R5 no iu_rd page0", {47'h0, c_rd}, 48'h0);
  endtask

  task automatic t_page12();
    wr(4'h7, 8'h40);
    wr(4'h9, 8'h33);
    check("R6 page1 fwd", {38'h0, c_wr, c_page, c_idx, c_wdata}, {38'h0, 1'b1, 2'd1, 2'd1, 8'h33});
    rd(4'h9, rv); check("R6 page1 read zero", {40'h0, rv}, 48'h0);
    check("R6 page1 no iu_rd", {47'h0, c_rd}, 48'h0);
    wr(4'h7, 8'h80);
    wr(4'hA, 8'hC7);
    check("R6 page2 fwd", {38'h0, c_wr, c_page, c_idx, c_wdata}, {38'h0, 1'b1, 2'd2, 2'd2, 8'hC7});
    rd(4'h8, rv); check("R6 page2 read zero", {40'h0, rv}, 48'h0);
  endtask

  task automatic t_page3();
    wr(4'h7, 8'hC0);
    rd(4'h8, rv); check("R7 id0", {39'h0, c_rd, rv}, {39'h0, 1'b1, 8'h90});
    rd(4'hA, rv); check("R7 id2", {39'h0, c_rd, rv}, {39'h0, 1'b1, 8'h92});
    wr(4'h8, 8'h01);
    check("R7 page3 write fwd", {38'h0, c_wr, c_page, c_idx, c_wdata}, {38'h0, 1'b1, 2'd3, 2'd0, 8'h01});
    iu_pend = 3'b101;
    rd(4'h6, rv); check("R8 pend page3", {40'h0, rv}, 48'h05);
    wr(4'h7, 8'h00);
  endtask

  task automatic t_pend();
    iu_pend = 3'b011;
    rd(4'h6, rv); check("R8 pend page0", {40'h0, rv}, 48'h03);
    iu_pend = 3'b000;
    rd(4'h6, rv); check("R8 pend clear", {40'h0, rv}, 48'h00);
  endtask

  task automatic t_unused();
    wr(4'hC, 8'hFF);
    check("R9 unused write no iu_wr", {47'h0, c_wr}, 48'h0);
    check("R9 unused write no drive", pad_drive_low, 48'h0);
    rd(4'hB, rv); check("R9 0xB zero", {40'h0, rv}, 48'h0);
    rd(4'hF, rv); check("R9 0xF zero", {40'h0, rv}, 48'h0);
  endtask

  task automatic t_hold();
    iu_pend = 3'b110;
    rd(4'h6, rv);
    iu_pend = 3'b001;
    repeat (3) @(negedge clk);
    check("R10 rdata held", {40'h0, bus_rdata}, 48'h06);
    iu_pend = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_drive(); t_input(); t_lock(); t_page0();
    t_page12(); t_page3(); t_pend(); t_unused(); t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule